// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block brings a second processor core out of its powered-down state in hardware. Software loads the address at which the core is to begin executing and, if needed, the number of cycles the clamp is held at each step. It then writes a start bit. From there the sequencer works through a fixed ordering without further help:

1. It holds the core in reset, clears the level-1 reset-disable control and keeps the debug power-up indication low.
2. It walks the 8-bit power-clamp vector down to zero, clearing one bit per step.
3. It waits a settle time of about 10 ms, then removes the power-off gating.
4. It waits about 1 ms, then releases both core reset bits in the same cycle.
5. It raises the debug power-up indication and reports done.

Both long waits are cycle counts computed from the clock frequency parameter. The control interface is a plain single-cycle write port and a combinational read port. The outputs toward the core are level signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `core_wake_seq`

## Requirements
- R1: After synchronous reset: `core_rst`=2'b00, `clamp`=8'hFF, `pwr_gate`=1, `dbg_pwrup`=0, `l1_rst_dis`=1, `busy`=0, `done`=0, `boot_addr`=0, and the hold register reads 1.
- R2: A write to address 0 with data bit 0 set, made while idle, sets `busy` and clears `done` at that clock edge. On the following edge (the preparation edge) the block drives `core_rst`=0, `l1_rst_dis`=0, `dbg_pwrup`=0, `pwr_gate`=1 and `clamp`=8'hFF.
- R3: The clamp then steps 8'h7F, 3F, 1F, 0F, 07, 03, 01, 00, each step clearing the highest set bit. Step k (k=1..8) lands k*H edges after the preparation edge. H is bits [7:0] of the hold register at address 2, and a value of 0 is treated as 1.
- R4: `pwr_gate` falls SETTLE edges after the clamp reaches zero, where SETTLE = CLK_HZ/1e6 * SETTLE_US.
- R5: `core_rst` goes from 2'b00 to 2'b11, both bits in the same edge, GATE edges after `pwr_gate` falls, where GATE = CLK_HZ/1e6 * GATE_US. This happens only with the clamp at zero and the gating clear.
- R6: One edge after the reset release, `dbg_pwrup` rises; on that same edge `busy` falls and `done` rises. `dbg_pwrup` is never high unless `core_rst`=2'b11.
- R7: `done` stays set until the next accepted start or reset. A start written while `busy` is ignored: the timing of R3 to R6 is unchanged.
- R8: A write to address 1 sets `boot_addr` (32 bits). Writes to address 1 or address 2 while `busy` are ignored.
- R9: Reads are combinational on `rd_addr`: address 0 returns status (bit 0 busy, bit 1 done), address 1 returns the boot address, address 2 returns the hold value, and address 3 returns 0.
- R10: Asserting `rst` in the middle of a sequence returns every output to the R1 state on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| boot_addr | output | 32 | Entry address presented to the core |
| core_rst | output | 2 | Core reset control, 0 = both resets held, 3 = both released |
| clamp | output | 8 | Power-clamp vector, all ones = fully clamped |
| pwr_gate | output | 1 | Power-off gating, 1 = core power gated |
| l1_rst_dis | output | 1 | Level-1 reset-disable control |
| dbg_pwrup | output | 1 | Debug power-up indication |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sticky completion flag |

## Verification
The assertions check ordering rules that must hold on every cycle:
- every clamp change is a one-bit right shift or a reload to all ones;
- gating falls only with the clamp at zero;
- the reset bits move together and release only after the clamp and gating are clear;
- debug power-up implies released reset;
- busy and done are exclusive;
- the boot address holds while busy;
- the reset state holds after reset.

Only the bench scenarios can show the exact edge counts of each clamp step and wait, the effect of different hold values including zero, that a second start changes no timing, and that a mid-sequence reset ends the run.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_BOOT = 2'd1;
  localparam logic [ADDR_W-1:0] A_HOLD = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREP,
    ST_CLAMP,
    ST_SETTLE,
    ST_UNGATE,
    ST_DBG
  } cws_state_e;
endpackage

// File: rtl/cws_regs.sv
module cws_regs
  import cws_pkg::*;
#(
  parameter int DW     = 32,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              busy,
  input  logic              done,
  output logic              start_req,
  output logic [DW-1:0]     boot_addr,
  output logic [HOLD_W-1:0] hold_cyc
);
  // Configuration is frozen while a sequence runs.
  always_ff @(posedge clk) begin
    if (rst) begin
      boot_addr <= '0;
      hold_cyc  <= HOLD_W'(1);
    end else if (wr_en && !busy) begin
      if (wr_addr == A_BOOT) boot_addr <= wr_data;
      if (wr_addr == A_HOLD) hold_cyc  <= wr_data[HOLD_W-1:0];
    end
  end

  assign start_req = wr_en && (wr_addr == A_CTRL) && wr_data[0];

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(DW-2){1'b0}}, done, busy};
      A_BOOT:  rd_data = boot_addr;
      A_HOLD:  rd_data = DW'(hold_cyc);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cws_timer.sv
module cws_timer #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         expire
);
  logic [W-1:0] cnt;

  // limit is at least 1; expire marks the last cycle of the window.
  assign expire = (cnt >= (limit - W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (!expire)   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/cws_clamp.sv
module cws_clamp #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset,
  input  logic         step,
  output logic [N-1:0] vec,
  output logic         last
);
  logic [N-1:0] shifted;

  // Each step drops the highest remaining set bit.
  for (genvar g = 0; g < N; g++) begin : g_bit
    if (g == N - 1) begin : g_top
      assign shifted[g] = 1'b0;
    end else begin : g_low
      assign shifted[g] = vec[g+1];
    end
  end

  assign last = (vec == N'(1));

  always_ff @(posedge clk) begin
    if (rst || preset) vec <= '1;
    else if (step)     vec <= shifted;
  end
endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import cws_pkg::*;
#(
  parameter int CLK_HZ    = 250_000_000,
  parameter int SETTLE_US = 10_000,
  parameter int GATE_US   = 1_000,
  parameter int HOLD_W    = 8,
  parameter int CLAMP_W   = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] boot_addr,
  output logic [1:0]        core_rst,
  output logic [CLAMP_W-1:0] clamp,
  output logic              pwr_gate,
  output logic              l1_rst_dis,
  output logic              dbg_pwrup,
  output logic              busy,
  output logic              done
);
  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SETTLE_RAW = CYC_PER_US * SETTLE_US;
  localparam int GATE_RAW   = CYC_PER_US * GATE_US;
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW;
  localparam int GATE_CYC   = (GATE_RAW < 1) ? 1 : GATE_RAW;
  localparam int HOLD_MAX   = 1 << HOLD_W;
  localparam int MAX_A      = (SETTLE_CYC > GATE_CYC) ? SETTLE_CYC : GATE_CYC;
  localparam int MAX_CYC    = (MAX_A > HOLD_MAX) ? MAX_A : HOLD_MAX;
  localparam int CNT_W      = $clog2(MAX_CYC) + 1;

  cws_state_e        state;
  logic              start_req;
  logic [HOLD_W-1:0] hold_cyc;
  logic [HOLD_W-1:0] hold_eff;
  logic [CNT_W-1:0]  limit;
  logic              expire;
  logic              restart;
  logic              clamp_step;
  logic              clamp_preset;
  logic              clamp_last;

  cws_regs #(.DW(DATA_W), .HOLD_W(HOLD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .busy      (busy),
    .done      (done),
    .start_req (start_req),
    .boot_addr (boot_addr),
    .hold_cyc  (hold_cyc)
  );

  assign hold_eff = (hold_cyc == '0) ? HOLD_W'(1) : hold_cyc;

  always_comb begin
    case (state)
      ST_CLAMP:  limit = CNT_W'(hold_eff);
      ST_SETTLE: limit = CNT_W'(SETTLE_CYC);
      ST_UNGATE: limit = CNT_W'(GATE_CYC);
      default:   limit = CNT_W'(1);
    endcase
  end

  assign restart = (state == ST_PREP) ||
                   (expire && (state == ST_CLAMP || state == ST_SETTLE || state == ST_UNGATE));
  assign clamp_step   = (state == ST_CLAMP) && expire;
  assign clamp_preset = (state == ST_PREP);

  cws_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .limit   (limit),
    .expire  (expire)
  );

  cws_clamp #(.N(CLAMP_W)) u_clamp (
    .clk    (clk),
    .rst    (rst),
    .preset (clamp_preset),
    .step   (clamp_step),
    .vec    (clamp),
    .last   (clamp_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      core_rst   <= 2'b00;
      pwr_gate   <= 1'b1;
      l1_rst_dis <= 1'b1;
      dbg_pwrup  <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_req) begin
            state <= ST_PREP;
            busy  <= 1'b1;
            done  <= 1'b0;
          end
        end
        ST_PREP: begin
          core_rst   <= 2'b00;
          l1_rst_dis <= 1'b0;
          dbg_pwrup  <= 1'b0;
          pwr_gate   <= 1'b1;
          state      <= ST_CLAMP;
        end
        ST_CLAMP: begin
          if (expire && clamp_last) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (expire) begin
            pwr_gate <= 1'b0;
            state    <= ST_UNGATE;
          end
        end
        ST_UNGATE: begin
          if (expire) begin
            core_rst <= 2'b11;
            state    <= ST_DBG;
          end
        end
        ST_DBG: begin
          dbg_pwrup <= 1'b1;
          busy      <= 1'b0;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cws_check.sv
module cws_check #(
  parameter int CW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    core_rst,
  input logic [CW-1:0] clamp,
  input logic          pwr_gate,
  input logic          l1_rst_dis,
  input logic          dbg_pwrup,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] boot_addr
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (core_rst == 2'b00 && (&clamp) && pwr_gate && l1_rst_dis &&
                    !dbg_pwrup && !busy && !done));

  p_clamp_walk_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(clamp) |-> ((clamp == ($past(clamp) >> 1)) || (&clamp)));

  p_gate_after_clamp_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_gate) |-> (clamp == '0));

  p_reset_pair_r5: assert property (@(posedge clk) disable iff (rst)
    (core_rst == 2'b00) || (core_rst == 2'b11));

  p_release_order_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(core_rst[0]) |-> (clamp == '0 && !pwr_gate));

  p_dbg_after_release_r6: assert property (@(posedge clk) disable iff (rst)
    dbg_pwrup |-> (core_rst == 2'b11));

  p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_boot_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(boot_addr));
endmodule

bind core_wake_seq cws_check #(.CW(CLAMP_W), .DW(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .core_rst   (core_rst),
  .clamp      (clamp),
  .pwr_gate   (pwr_gate),
  .l1_rst_dis (l1_rst_dis),
  .dbg_pwrup  (dbg_pwrup),
  .busy       (busy),
  .done       (done),
  .boot_addr  (boot_addr)
);

// File: tb/tb_core_wake_seq.sv
`timescale 1ns/1ps
module tb_core_wake_seq;
  localparam int S = 20;  // settle cycles at 1 MHz / 20 us
  localparam int G = 7;   // gate cycles at 1 MHz / 7 us

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [31:0] boot_addr;
  logic [1:0]  core_rst;
  logic [7:0]  clamp;
  logic        pwr_gate, l1_rst_dis, dbg_pwrup, busy, done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  core_wake_seq #(.CLK_HZ(1_000_000), .SETTLE_US(S), .GATE_US(G)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .boot_addr(boot_addr), .core_rst(core_rst),
    .clamp(clamp), .pwr_gate(pwr_gate), .l1_rst_dis(l1_rst_dis), .dbg_pwrup(dbg_pwrup),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(req, $sformatf("read addr %0d", a), rd_data, exp);
  endtask

  task automatic chk_reset_outputs(input string req);
    chk(req, "core_rst", core_rst, 2'b00);
    chk(req, "clamp", clamp, 8'hFF);
    chk(req, "pwr_gate", pwr_gate, 1);
    chk(req, "dbg_pwrup", dbg_pwrup, 0);
    chk(req, "l1_rst_dis", l1_rst_dis, 1);
    chk(req, "busy", busy, 0);
    chk(req, "done", done, 0);
    chk(req, "boot_addr", boot_addr, 0);
    rd_chk(req, 2'd2, 32'd1);
  endtask

  task automatic t_reset_state();
    chk_reset_outputs("R1");
  endtask

  task automatic t_regs();
    wr(2'd1, 32'h4000_8000);
    wr(2'd2, 32'h0000_0103);  // only bits [7:0] kept
    chk("R8", "boot_addr", boot_addr, 32'h4000_8000);
    rd_chk("R9", 2'd1, 32'h4000_8000);
    rd_chk("R9", 2'd2, 32'd3);
    rd_chk("R9", 2'd3, 32'd0);
    rd_chk("R9", 2'd0, 32'd0);
  endtask

  // Starts a sequence and measures every event in edges after the start edge.
  task automatic run_seq(input int h, input bit inject, input string tag);
    int heff = (h == 0) ? 1 : h;
    int ct[8];
    logic [7:0] cv[8];
    int nc = 0;
    int gf = -1, rl = -1, dg = -1, dn = -1, bz = -1;
    logic [7:0] prev = 8'hFF;
    logic [31:0] boot_before = boot_addr;
    for (int k = 0; k < 8; k++) begin ct[k] = -1; cv[k] = 8'hxx; end
    wr(2'd0, 32'd1);
    chk("R2", {tag, " busy after start"}, busy, 1);
    chk("R2", {tag, " done cleared by start"}, done, 0);
    for (int i = 1; i < 3000 && dn < 0; i++) begin
      @(negedge clk);
      if (i == 1) begin
        chk("R2", {tag, " prep core_rst"}, core_rst, 2'b00);
        chk("R2", {tag, " prep l1_rst_dis"}, l1_rst_dis, 0);
        chk("R2", {tag, " prep dbg_pwrup"}, dbg_pwrup, 0);
        chk("R2", {tag, " prep pwr_gate"}, pwr_gate, 1);
        chk("R2", {tag, " prep clamp"}, clamp, 8'hFF);
        prev = clamp;
      end else if (clamp != prev) begin
        if (nc < 8) begin ct[nc] = i; cv[nc] = clamp; end
        nc++;
        prev = clamp;
      end
      if (gf < 0 && !pwr_gate) gf = i;
      if (rl < 0 && core_rst == 2'b11) rl = i;
      if (dg < 0 && dbg_pwrup) dg = i;
      if (dn < 0 && done) dn = i;
      if (bz < 0 && !busy) bz = i;
      if (inject) begin
        if (i == 3) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'd1; end
        if (i == 4) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'hDEAD_0000; end
        if (i == 5) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'd9; end
        if (i == 6) wr_en = 1'b0;
      end
    end
    chk("R3", {tag, " clamp step count"}, nc, 8);
    for (int k = 0; k < 8; k++) begin
      chk("R3", $sformatf("%s step %0d edge", tag, k + 1), ct[k], 1 + (k + 1) * heff);
      chk("R3", $sformatf("%s step %0d value", tag, k + 1), cv[k], 8'hFF >> (k + 1));
    end
    chk("R4", {tag, " gate fall edge"}, gf, 1 + 8 * heff + S);
    chk("R5", {tag, " reset release edge"}, rl, gf + G);
    chk("R5", {tag, " core_rst final"}, core_rst, 2'b11);
    chk("R6", {tag, " dbg rise edge"}, dg, rl + 1);
    chk("R6", {tag, " done rise edge"}, dn, rl + 1);
    chk("R6", {tag, " busy fall edge"}, bz, rl + 1);
    if (inject) begin
      chk("R8", {tag, " boot locked while busy"}, boot_addr, boot_before);
      rd_chk("R8", 2'd2, 32'(h));
    end
  endtask

  task automatic t_done_sticky();
    repeat (10) @(negedge clk);
    chk("R7", "done sticky", done, 1);
    rd_chk("R9", 2'd0, 32'd2);
  endtask

  task automatic t_midreset();
    wr(2'd1, 32'h1234_5678);
    wr(2'd0, 32'd1);
    repeat (12) @(negedge clk);
    chk("R10", "clamp moved before reset", (clamp != 8'hFF), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_reset_outputs("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst = 1'b0;
    t_regs();
    run_seq(3, 1'b0, "h3");
    t_done_sticky();
    run_seq(3, 1'b0, "rerun");
    wr(2'd2, 32'd1);
    run_seq(1, 1'b0, "h1");
    wr(2'd2, 32'd0);
    run_seq(0, 1'b0, "h0");
    wr(2'd2, 32'd2);
    run_seq(2, 1'b1, "R7 inject");
    t_midreset();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule